// File: doc/BRIEF.md
# Look-Ahead Adder/Subtractor

This block adds or subtracts two two's-complement operands of a configurable width in a single combinational path. A mode input selects the operation: with mode low the operands are summed, with mode high the second operand is subtracted from the first. Internally the second operand is inverted under control of the mode bit and the mode bit also serves as the carry into the lowest stage. Subtraction is therefore performed as the first operand plus the inverted second operand plus one.

The datapath is split into 4-bit slices. Every slice forms per-bit propagate (XOR) and generate (AND) terms and derives all of its internal carries directly from those terms, so that the carries inside a slice do not ripple bit by bit. Slices are chained: each slice's carry out is the next slice's carry in. Besides the result, the block reports the carry out of the top bit (the unsigned overflow, or "no borrow" when subtracting) and a signed overflow flag. The flag is formed from the carry into the top bit and the carry out of the top bit.

The block has no clock and holds no state. Its outputs follow the inputs after the combinational delay, and the width must be a multiple of four.

Top module: `lookahead_addsub`

## Requirements
- R1: With sub_mode = 0, result equals (opnd_a + opnd_b) modulo 2^WIDTH.
- R2: With sub_mode = 1, result equals (opnd_a - opnd_b) modulo 2^WIDTH.
- R3: With sub_mode = 0, carry_out equals bit WIDTH of the unsigned sum opnd_a + opnd_b.
- R4: With sub_mode = 1, carry_out is 1 when opnd_a >= opnd_b as unsigned numbers and 0 otherwise (0 signals a borrow).
- R5: With sub_mode = 0, ovf_signed is 1 exactly when the operands' top bits are equal and the result's top bit differs from them.
- R6: With sub_mode = 1, ovf_signed is 1 exactly when the operands' top bits differ and the result's top bit differs from opnd_a's top bit.
- R7: A carry produced in the lowest 4-bit slice travels through every higher slice: all-ones plus one gives result 0 with carry_out 1.
- R8: The outputs depend only on the present inputs. Changing sub_mode with the operands held reselects the operation with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand (minuend when subtracting) |
| opnd_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 selects addition, 1 selects subtraction |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the top bit |
| ovf_signed | output | 1 | Two's-complement overflow |

## Verification
Carry out and signed overflow can both be raised by the same operand pair. This happens when two negative operands large in magnitude are added, for example the most negative value added to itself, which gives a zero result. The bench applies such pairs, together with single-flag cases such as the largest positive value plus one, and judges each flag separately against values derived from the unsigned-range rule and the sign rule. A full sweep of every operand pair in both modes then confirms that the two flags never interfere with each other or with the result.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int GROUP_BITS = 4;

  typedef struct packed {
    logic [GROUP_BITS-1:0] prop;
    logic [GROUP_BITS-1:0] gen;
  } pg_t;
endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             invert,
  output logic [WIDTH-1:0] b_out
);
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      b_out[i] = b_in[i] ^ invert;
    end
  end

  always_comb begin
    if (invert) begin
      assert (b_out == ~b_in) else $error("prep: b not inverted in sub mode (R2)");
    end else begin
      assert (b_out == b_in) else $error("prep: b altered in add mode (R1)");
    end
  end
endmodule

// File: rtl/lookahead_group.sv
module lookahead_group
  import addsub_pkg::*;
(
  input  logic [GROUP_BITS-1:0] a,
  input  logic [GROUP_BITS-1:0] b,
  input  logic                  cin,
  output logic [GROUP_BITS-1:0] sum,
  output logic                  cout,
  output logic                  c_top
);
  pg_t pg;
  logic [GROUP_BITS:0] c;

  always_comb begin
    pg.prop = a ^ b;
    pg.gen  = a & b;
  end

  // every carry taken straight from propagate/generate and cin
  always_comb begin
    c[0] = cin;
    c[1] = pg.gen[0] | (pg.prop[0] & cin);
    c[2] = pg.gen[1] | (pg.prop[1] & pg.gen[0])
         | (pg.prop[1] & pg.prop[0] & cin);
    c[3] = pg.gen[2] | (pg.prop[2] & pg.gen[1])
         | (pg.prop[2] & pg.prop[1] & pg.gen[0])
         | (pg.prop[2] & pg.prop[1] & pg.prop[0] & cin);
    c[4] = pg.gen[3] | (pg.prop[3] & pg.gen[2])
         | (pg.prop[3] & pg.prop[2] & pg.gen[1])
         | (pg.prop[3] & pg.prop[2] & pg.prop[1] & pg.gen[0])
         | (pg.prop[3] & pg.prop[2] & pg.prop[1] & pg.prop[0] & cin);
  end

  always_comb begin
    sum   = pg.prop ^ c[GROUP_BITS-1:0];
    cout  = c[GROUP_BITS];
    c_top = c[GROUP_BITS-1];
  end

  // slice sum must match plain addition of its inputs
  always_comb begin
    p_group_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {4'b0, cin}))
      else $error("group: look-ahead sum mismatch (R1)");
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags (
  input  logic c_into_msb,
  input  logic c_out_msb,
  output logic ovf
);
  always_comb ovf = c_into_msb ^ c_out_msb;
endmodule

// File: rtl/lookahead_addsub.sv
module lookahead_addsub
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf_signed
);
  localparam int NGROUPS = WIDTH / GROUP_BITS;
  localparam int MSB     = WIDTH - 1;

  logic [WIDTH-1:0]   b_cond;
  logic [NGROUPS:0]   gcarry;
  logic [NGROUPS-1:0] gtop;

  addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b_in   (opnd_b),
    .invert (sub_mode),
    .b_out  (b_cond)
  );

  always_comb gcarry[0] = sub_mode;

  for (genvar k = 0; k < NGROUPS; k++) begin : g_slice
    lookahead_group u_grp (
      .a     (opnd_a[k*GROUP_BITS +: GROUP_BITS]),
      .b     (b_cond[k*GROUP_BITS +: GROUP_BITS]),
      .cin   (gcarry[k]),
      .sum   (result[k*GROUP_BITS +: GROUP_BITS]),
      .cout  (gcarry[k+1]),
      .c_top (gtop[k])
    );

    logic [GROUP_BITS-1:0] low_part;
    always_comb begin
      low_part = {1'b0, opnd_a[k*GROUP_BITS +: GROUP_BITS-1]}
               + {1'b0, b_cond[k*GROUP_BITS +: GROUP_BITS-1]}
               + {{(GROUP_BITS-1){1'b0}}, gcarry[k]};
      p_slice_topcarry_r7: assert (gtop[k] == low_part[GROUP_BITS-1])
        else $error("slice carry into top bit wrong (R7)");
    end
  end

  always_comb carry_out = gcarry[NGROUPS];

  addsub_flags u_flags (
    .c_into_msb (gtop[NGROUPS-1]),
    .c_out_msb  (gcarry[NGROUPS]),
    .ovf        (ovf_signed)
  );

  logic [WIDTH:0] ref_add;
  logic           ref_ge;
  always_comb begin
    ref_add = {1'b0, opnd_a} + {1'b0, opnd_b};
    ref_ge  = (opnd_a >= opnd_b);
    if (!sub_mode) begin
      p_add_result_r1: assert (result == ref_add[WIDTH-1:0])
        else $error("sum wrong (R1)");
      p_add_carry_r3: assert (carry_out == ref_add[WIDTH])
        else $error("add carry wrong (R3)");
      p_add_ovf_r5: assert (ovf_signed ==
          ((opnd_a[MSB] == opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])))
        else $error("add overflow wrong (R5)");
    end else begin
      p_sub_result_r2: assert (result == WIDTH'(opnd_a - opnd_b))
        else $error("difference wrong (R2)");
      p_sub_borrow_r4: assert (carry_out == ref_ge)
        else $error("sub carry wrong (R4)");
      p_sub_ovf_r6: assert (ovf_signed ==
          ((opnd_a[MSB] != opnd_b[MSB]) && (result[MSB] != opnd_a[MSB])))
        else $error("sub overflow wrong (R6)");
    end
  end
endmodule

// File: tb/sim_lookahead_addsub.sv
`timescale 1ns/1ps
module sim_lookahead_addsub;
  localparam int W = 8;

  logic clk = 1'b0;
  logic [W-1:0] a, b;
  logic         m;
  logic [W-1:0] res;
  logic         co, ov;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lookahead_addsub #(.WIDTH(W)) u0 (
    .opnd_a(a), .opnd_b(b), .sub_mode(m),
    .result(res), .carry_out(co), .ovf_signed(ov)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h (a=%0h b=%0h mode=%0b)",
               tag, act, exp, a, b, m);
    end
  endtask

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic mv);
    @(negedge clk);
    a = av; b = bv; m = mv;
    #1;
  endtask

  // full expectation from the requirement rules
  task automatic expect_all(input string ctx);
    logic [W:0] full;
    logic e_ov;
    if (!m) begin
      full = {1'b0, a} + {1'b0, b};
      e_ov = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
      check({ctx, " R1 result"}, int'(res), int'(full[W-1:0]));
      check({ctx, " R3 carry"}, int'(co), int'(full[W]));
      check({ctx, " R5 ovf"}, int'(ov), int'(e_ov));
    end else begin
      full = {1'b0, a} + {1'b0, ~b} + 1;
      e_ov = (a[W-1] != b[W-1]) && (full[W-1] != a[W-1]);
      check({ctx, " R2 result"}, int'(res), int'(full[W-1:0]));
      check({ctx, " R4 carry"}, int'(co), int'(a >= b));
      check({ctx, " R6 ovf"}, int'(ov), int'(e_ov));
    end
  endtask

  task automatic t_zero_inputs;
    apply('0, '0, 1'b0);
    check("zero R1 result", int'(res), 0);
    check("zero R3 carry", int'(co), 0);
    check("zero R5 ovf", int'(ov), 0);
  endtask

  task automatic t_carry_chain;
    apply({W{1'b1}}, 1, 1'b0);
    check("chain R7 result", int'(res), 0);
    check("chain R7 carry", int'(co), 1);
    check("chain R5 ovf", int'(ov), 0);
  endtask

  task automatic t_both_flags;
    apply({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0);
    check("both R1 result", int'(res), 0);
    check("both R3 carry", int'(co), 1);
    check("both R5 ovf", int'(ov), 1);
  endtask

  task automatic t_pos_overflow;
    apply({1'b0, {(W-1){1'b1}}}, 1, 1'b0);
    check("posovf R1 result", int'(res), 1 << (W-1));
    check("posovf R3 carry", int'(co), 0);
    check("posovf R5 ovf", int'(ov), 1);
  endtask

  task automatic t_sub_equal;
    apply(8'h5A, 8'h5A, 1'b1);
    check("subeq R2 result", int'(res), 0);
    check("subeq R4 carry", int'(co), 1);
    check("subeq R6 ovf", int'(ov), 0);
  endtask

  task automatic t_sub_borrow;
    apply(8'h03, 8'h05, 1'b1);
    check("borrow R2 result", int'(res), 8'hFE);
    check("borrow R4 carry", int'(co), 0);
    check("borrow R6 ovf", int'(ov), 0);
  endtask

  task automatic t_sub_overflow;
    apply(8'h80, 8'h01, 1'b1);
    check("subovf R2 result", int'(res), 8'h7F);
    check("subovf R4 carry", int'(co), 1);
    check("subovf R6 ovf", int'(ov), 1);
  endtask

  task automatic t_mode_switch;
    apply(8'h05, 8'h03, 1'b0);
    check("switch R8 add", int'(res), 8'h08);
    #1 m = 1'b1;
    #1 check("switch R8 sub", int'(res), 8'h02);
  endtask

  task automatic t_sweep;
    for (int ia = 0; ia < (1 << W); ia++) begin
      for (int ib = 0; ib < (1 << W); ib++) begin
        for (int im = 0; im < 2; im++) begin
          a = W'(ia); b = W'(ib); m = im[0];
          #0.05;
          expect_all("sweep");
        end
      end
    end
  endtask

  initial begin
    a = '0; b = '0; m = 1'b0;
    t_zero_inputs();
    t_carry_chain();
    t_both_flags();
    t_pos_overflow();
    t_sub_equal();
    t_sub_borrow();
    t_sub_overflow();
    t_mode_switch();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule